// File: doc/BRIEF.md
# Masked Prioritized Interrupt Controller

This block collects interrupt raises from N hardware lines (32 by default) and decides which one the CPU should take. Every raise is latched in a raw-pending vector whatever the enable mask says. A line's effective status bit is set only while its mask bit allows it. The controller therefore remembers raises that arrive while a line is disabled, and fires them the moment software enables that line.

Each line carries an 8-bit priority, where a smaller value is more urgent. The CPU side supplies the priority of the handler it is running, using a 9-bit value that reads 256 when no handler is active. A combinational arbiter picks the pending line with the lowest priority value that is also strictly below the running priority; on a tie the lowest index wins. A registered request goes to the CPU while a winner exists and the global lock is clear, or while the lock-ignore flag is set.

Software issues one command per cycle on a small command port. A command can enable, disable or clear a line, set a line's priority, clear all enabled lines, clear everything, or write the lock and lock-ignore flags. A line command whose index is at or above N changes no state and sets a sticky error flag.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A high bit on `raise_i` always sets that line's raw-pending bit (`pend_o`). It sets that line's status bit (`stat_o`) only if the mask bit (`mask_o`) for that line is 1 after the same edge. A mask bit of 1 means unmasked.
- R2: ENABLE (op 1) sets the mask bit for the line. If that line's raw-pending bit is already set, ENABLE also sets its status bit at the same edge.
- R3: CLEAR (op 3) zeroes both the status bit and the raw-pending bit of the line. DISABLE (op 2) zeroes only the mask bit and leaves the status and raw-pending bits as they are.
- R4: CLEAR_ENABLED (op 5) zeroes the whole status vector. It also zeroes raw-pending bits, but only where the mask bit is 1.
- R5: CLEAR_ALL (op 6) zeroes the status vector and the raw-pending vector completely.
- R6: SET_PRIO (op 4) writes `cmd_data_i` as the line's priority. The winner is the status line whose priority value is lowest and strictly below `run_prio_i`; on a tie the lowest index wins. The value 256 on `run_prio_i` lets any priority win.
- R7: When no status line qualifies, `win_valid_o` is 0 and `win_idx_o` is 0. The outputs `win_valid_o` and `win_idx_o` follow the registered state and `run_prio_i` combinationally.
- R8: `irq_o` is a register. After each edge it equals the value that `win_valid_o`, ANDed with (lock clear or lock-ignore set), had just before that edge. While locked without lock-ignore, raises are still latched.
- R9: SET_LOCK (op 7) loads `cmd_data_i[0]` into the lock flag (`lock_o`) and `cmd_data_i[1]` into the lock-ignore flag. It also loads the previous lock value into `prev_lock_o`. After an unlock, `irq_o` rises one edge later if a winner is pending.
- R10: After reset, all vectors are zero and all priorities are 255. The lock and lock-ignore flags, `irq_o`, `prev_lock_o` and `err_o` are all 0.
- R11: ENABLE, DISABLE, CLEAR or SET_PRIO with `cmd_idx_i` >= N changes no mask, status, raw-pending or priority state. It sets `err_o`, and `err_o` stays set until reset.
- R12: A raise and a CLEAR of the same line in the same cycle leave both its raw-pending and status bits set, provided the line is unmasked. The raise takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_i | input | N | Per-line raise strobes |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command code (0 NOP, 1 ENABLE, 2 DISABLE, 3 CLEAR, 4 SET_PRIO, 5 CLEAR_ENABLED, 6 CLEAR_ALL, 7 SET_LOCK) |
| cmd_idx_i | input | $clog2(N)+1 | Line index for line commands |
| cmd_data_i | input | PW | Priority value, or lock bit [0] and lock-ignore bit [1] |
| run_prio_i | input | PW+1 | Priority of the running handler, 256 when none |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| win_valid_o | output | 1 | A qualifying winner exists |
| win_idx_o | output | $clog2(N)+1 | Winning line index |
| pend_o | output | N | Raw-pending vector |
| stat_o | output | N | Effective status vector |
| mask_o | output | N | Enable mask |
| lock_o | output | 1 | Lock flag |
| prev_lock_o | output | 1 | Lock value before the last SET_LOCK |
| err_o | output | 1 | Sticky out-of-range index error |

## Verification
A hardware raise and a software command can hit the same line on the same edge. The bench provokes a raise together with a CLEAR of that line, and a raise arriving while CLEAR_ENABLED runs on a masked line. A reference model applies the command first and then ORs the raise in, and each post-edge vector and the winner are compared against that model. The bench also covers the lock path: a lock followed by an unlock, judged by the one-edge delay of `irq_o`.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N  = 32,
  parameter int PW = 8,
  localparam int IW = $clog2(N) + 1,
  localparam int RW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  raise_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [IW-1:0] cmd_idx_i,
  input  logic [PW-1:0] cmd_data_i,
  input  logic [RW-1:0] run_prio_i,
  output logic          irq_o,
  output logic          win_valid_o,
  output logic [IW-1:0] win_idx_o,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  stat_o,
  output logic [N-1:0]  mask_o,
  output logic          lock_o,
  output logic          prev_lock_o,
  output logic          err_o
);
  localparam logic [2:0] OP_EN = 3'd1, OP_DIS = 3'd2, OP_CLR = 3'd3, OP_PRIO = 3'd4,
                         OP_CLREN = 3'd5, OP_CLRALL = 3'd6, OP_LOCK = 3'd7;

  logic [N-1:0]  pend_q, stat_q, mask_q;
  logic [N-1:0]  pend_n, stat_n, mask_n;
  logic [PW-1:0] prio_q [N];
  logic          lock_q, ign_q, irq_q, prev_q, err_q;

  logic          line_op, in_range, bad_idx;
  logic [N-1:0]  hit, do_en, do_dis, do_clr;
  logic          clr_en, clr_all, set_prio, set_lock;

  assign line_op  = cmd_valid_i && (cmd_op_i inside {OP_EN, OP_DIS, OP_CLR, OP_PRIO});
  assign in_range = cmd_idx_i < IW'(N);
  assign bad_idx  = line_op && !in_range;
  assign hit      = in_range ? (N'(1) << cmd_idx_i) : '0;
  assign do_en    = (cmd_valid_i && cmd_op_i == OP_EN)  ? hit : '0;
  assign do_dis   = (cmd_valid_i && cmd_op_i == OP_DIS) ? hit : '0;
  assign do_clr   = (cmd_valid_i && cmd_op_i == OP_CLR) ? hit : '0;
  assign clr_en   = cmd_valid_i && cmd_op_i == OP_CLREN;
  assign clr_all  = cmd_valid_i && cmd_op_i == OP_CLRALL;
  assign set_prio = cmd_valid_i && cmd_op_i == OP_PRIO && in_range;
  assign set_lock = cmd_valid_i && cmd_op_i == OP_LOCK;

  assign mask_n = (mask_q & ~do_dis) | do_en;
  assign pend_n = (pend_q & ~(do_clr | (clr_en ? mask_q : '0) | (clr_all ? '1 : '0))) | raise_i;
  assign stat_n = (stat_q & ~(do_clr | ((clr_en || clr_all) ? '1 : '0)))
                | (raise_i & mask_n) | (do_en & pend_q);

  logic [RW-1:0] best;
  always_comb begin
    best        = run_prio_i;
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (stat_q[i] && {1'b0, prio_q[i]} < best) begin
        best        = {1'b0, prio_q[i]};
        win_valid_o = 1'b1;
        win_idx_o   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
      lock_q <= 1'b0;
      ign_q  <= 1'b0;
      irq_q  <= 1'b0;
      prev_q <= 1'b0;
      err_q  <= 1'b0;
      for (int i = 0; i < N; i++) prio_q[i] <= '1;
    end else begin
      pend_q <= pend_n;
      stat_q <= stat_n;
      mask_q <= mask_n;
      irq_q  <= win_valid_o && (!lock_q || ign_q);
      if (bad_idx) err_q <= 1'b1;
      if (set_prio) prio_q[cmd_idx_i[IW-2:0]] <= cmd_data_i;
      if (set_lock) begin
        prev_q <= lock_q;
        lock_q <= cmd_data_i[0];
        ign_q  <= cmd_data_i[1];
      end
    end
  end

  assign irq_o       = irq_q;
  assign pend_o      = pend_q;
  assign stat_o      = stat_q;
  assign mask_o      = mask_q;
  assign lock_o      = lock_q;
  assign prev_lock_o = prev_q;
  assign err_o       = err_q;

  AST_STAT_IN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~pend_q) == '0); // R1
  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> ((stat_q >> win_idx_o) & N'(1)) != '0); // R6
  AST_IRQ_HAD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|stat_q)); // R8
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(!lock_q || ign_q)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R11
  AST_BAD_IDX_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    bad_idx |=> err_o && $stable(mask_o)); // R11
  AST_CLRALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && raise_i == '0) |=> pend_o == '0 && stat_o == '0); // R5
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int N = 32, PW = 8, IW = $clog2(N) + 1, RW = PW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] raise_i = '0;
  logic cmd_valid_i = 1'b0;
  logic [2:0] cmd_op_i = '0;
  logic [IW-1:0] cmd_idx_i = '0;
  logic [PW-1:0] cmd_data_i = '0;
  logic [RW-1:0] run_prio_i = RW'(256);
  logic irq_o, win_valid_o, lock_o, prev_lock_o, err_o;
  logic [IW-1:0] win_idx_o;
  logic [N-1:0] pend_o, stat_o, mask_o;

  prio_irq_ctrl #(.N(N), .PW(PW)) i_prio_irq_ctrl (.*);

  always #4 clk = ~clk;

  typedef struct packed {
    logic [N-1:0] pend, stat, mask;
    logic valid; logic [IW-1:0] idx;
    logic irq, lock, prev, err;
  } exp_t;

  exp_t  q_exp[$];
  string q_req[$];
  int checks = 0, fails = 0;

  logic [N-1:0] m_pend = '0, m_stat = '0, m_mask = '0;
  logic [PW-1:0] m_prio [N];
  logic m_lock = 0, m_ign = 0, m_prev = 0, m_err = 0;

  function automatic void mwin(input logic [N-1:0] st, input int run, output logic v, output logic [IW-1:0] ix);
    int best = run;
    v = 0; ix = '0;
    for (int i = 0; i < N; i++)
      if (st[i] && int'(m_prio[i]) < best) begin best = int'(m_prio[i]); v = 1; ix = IW'(i); end
  endfunction

  task automatic step(input string req, input logic [2:0] op, input int idx, input int data,
                      input logic [N-1:0] rs, input int run);
    exp_t e; logic v; logic [IW-1:0] ix; logic [N-1:0] hit, nm;
    @(negedge clk);
    cmd_valid_i = (op != 0); cmd_op_i = op; cmd_idx_i = IW'(idx);
    cmd_data_i = PW'(data); raise_i = rs; run_prio_i = RW'(run);
    mwin(m_stat, run, v, ix);
    e.irq = v && (!m_lock || m_ign);
    hit = (idx < N) ? (N'(1) << idx) : '0;
    if (op inside {3'd1, 3'd2, 3'd3, 3'd4} && idx >= N) m_err = 1;
    nm = m_mask;
    if (op == 1) nm = m_mask | hit;
    if (op == 2) nm = m_mask & ~hit;
    if (op == 1) m_stat = m_stat | (hit & m_pend);
    if (op == 3) begin m_stat &= ~hit; m_pend &= ~hit; end
    if (op == 4 && idx < N) m_prio[idx] = PW'(data);
    if (op == 5) begin m_stat = '0; m_pend &= ~m_mask; end
    if (op == 6) begin m_stat = '0; m_pend = '0; end
    if (op == 7) begin m_prev = m_lock; m_lock = data[0]; m_ign = data[1]; end
    m_mask = nm;
    m_pend |= rs;
    m_stat |= rs & nm;
    mwin(m_stat, run, v, ix);
    e.pend = m_pend; e.stat = m_stat; e.mask = m_mask; e.valid = v; e.idx = ix;
    e.lock = m_lock; e.prev = m_prev; e.err = m_err;
    @(posedge clk);
    #1;
    q_req.push_back(req);
    q_exp.push_back(e);
  endtask

  task automatic cmp(input string req, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      exp_t e; string r;
      wait (q_exp.size() > 0);
      e = q_exp.pop_front(); r = q_req.pop_front();
      cmp(r, "pend", pend_o, e.pend);
      cmp(r, "stat", stat_o, e.stat);
      cmp(r, "mask", mask_o, e.mask);
      cmp(r, "win_valid", N'(win_valid_o), N'(e.valid));
      cmp(r, "win_idx", N'(win_idx_o), N'(e.idx));
      cmp(r, "irq", N'(irq_o), N'(e.irq));
      cmp(r, "lock", N'(lock_o), N'(e.lock));
      cmp(r, "prev_lock", N'(prev_lock_o), N'(e.prev));
      cmp(r, "err", N'(err_o), N'(e.err));
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < N; i++) m_prio[i] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step("R10", 0, 0, 0, '0, 256);
    step("R1", 0, 0, 0, N'(1) << 3, 256);
    step("R2", 1, 3, 0, '0, 256);
    step("R8", 0, 0, 0, '0, 256);
    step("R6", 4, 3, 20, '0, 256);
    step("R6", 4, 5, 10, '0, 256);
    step("R6", 1, 5, 0, '0, 256);
    step("R1", 0, 0, 0, N'(1) << 5, 256);
    step("R6", 4, 7, 10, '0, 256);
    step("R6", 1, 7, 0, N'(1) << 7, 256);
    step("R6", 0, 0, 0, '0, 256);
    step("R7", 0, 0, 0, '0, 10);
    step("R7", 0, 0, 0, '0, 10);
    step("R6", 0, 0, 0, '0, 15);
    step("R3", 2, 3, 0, '0, 256);
    step("R3", 3, 5, 0, '0, 256);
    step("R9", 7, 0, 1, '0, 256);
    step("R8", 0, 0, 0, '0, 256);
    step("R8", 7, 0, 3, '0, 256);
    step("R8", 0, 0, 0, '0, 256);
    step("R9", 7, 0, 1, '0, 256);
    step("R1", 0, 0, 0, N'(1) << 12, 256);
    step("R9", 7, 0, 0, '0, 256);
    step("R9", 0, 0, 0, '0, 256);
    step("R11", 1, 40, 0, '0, 256);
    step("R11", 4, 33, 1, '0, 256);
    step("R11", 0, 0, 0, '0, 256);
    step("R12", 1, 9, 0, '0, 256);
    step("R12", 3, 9, 0, N'(1) << 9, 256);
    step("R4", 0, 0, 0, N'(1) << 20, 256);
    step("R4", 5, 0, 0, N'(1) << 21, 256);
    step("R4", 0, 0, 0, '0, 256);
    step("R5", 6, 0, 0, '0, 256);
    step("R5", 0, 0, 0, '0, 256);
    wait (q_exp.size() == 0);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule